// File: doc/BRIEF.md
# MII Receive Nibble Aligner

This block takes the 4-bit receive stream of a media-independent interface, already brought into the system clock domain, and turns it into byte-wide frame data. A nibble is taken only on cycles where both the receive data-valid input and the nibble strobe are high, so the system clock may run faster than the line. While it waits for a frame it hunts for the preamble and the start-of-frame delimiter. None of those nibbles is passed on. After the delimiter it pairs nibbles into bytes, low nibble first, and raises a byte strobe for each complete byte.

When data-valid drops, the block sends a single-cycle end-of-frame pulse. The pulse carries the frame length in bytes, a flag for an odd trailing nibble, a flag for a receive error, a flag for a collision, and a combined bad-frame flag. Later stages use this pulse to keep or discard the bytes they have already taken. Alignment is held in a two-state toggle. A nibble counter one bit wider than the byte length runs beside it. Its upper bits give the length and its lowest bit must always agree with the toggle.

Top module: `mii_rx_aligner`

## Requirements
- R1: While reset is held and in the first cycle after it, byte_vld_o, eof_o and every eof_* flag are 0.
- R2: Data starts only after at least two accepted 0x5 nibbles are followed directly by an accepted 0xD. A 0xD after just one 0x5, or any nibble other than 0x5/0xD during the preamble, sends the block back to hunting. Such a frame yields no byte strobe and no end pulse.
- R3: No preamble or delimiter nibble ever appears on byte_o.
- R4: The first data nibble after the delimiter becomes byte_o[3:0] and the second becomes byte_o[7:4]. byte_vld_o is high for the one cycle after the clock edge that accepted the second nibble.
- R5: A cycle with rx_dv_i high and rx_nib_vld_i low has no effect, whatever value rx_nib_i carries.
- R6: byte_vld_o is never high in two consecutive cycles.
- R7: eof_o is a one-cycle pulse, high in the cycle after the first edge that samples rx_dv_i low once the delimiter has been found. It does not appear for a frame whose delimiter was never found.
- R8: eof_len_o equals the number of data nibbles after the delimiter, divided by two and rounded down.
- R9: With an odd data nibble count, eof_odd_o and eof_bad_o are 1 at the end pulse. The final lone nibble is not forwarded.
- R10: rx_er_i high on any cycle with rx_dv_i high sets eof_rxer_o and eof_bad_o for that frame. rx_er_i while rx_dv_i is low has no effect.
- R11: rx_col_i high on any cycle with rx_dv_i high sets eof_col_o and eof_bad_o for that frame. rx_col_i while rx_dv_i is low has no effect.
- R12: Error, collision and odd flags do not carry over into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_nib_i | input | 4 | Received nibble |
| rx_nib_vld_i | input | 1 | Nibble strobe: rx_nib_i holds a new nibble |
| rx_dv_i | input | 1 | Receive data valid (frame envelope) |
| rx_er_i | input | 1 | Receive error indication |
| rx_col_i | input | 1 | Collision indication |
| byte_o | output | 8 | Assembled frame byte |
| byte_vld_o | output | 1 | byte_o holds a new byte this cycle |
| eof_o | output | 1 | End-of-frame pulse |
| eof_len_o | output | LEN_W | Frame length in bytes, valid with eof_o |
| eof_odd_o | output | 1 | Odd (dribble) nibble seen, valid with eof_o |
| eof_rxer_o | output | 1 | Receive error seen, valid with eof_o |
| eof_col_o | output | 1 | Collision seen, valid with eof_o |
| eof_bad_o | output | 1 | Frame should be discarded, valid with eof_o |

## Verification
The sweep covers every data nibble count from zero to nine, plus one long frame, each with and without idle strobe gaps that carry junk nibbles. A design with a swapped nibble order, a toggle that is not reset at the delimiter, or a strobe that fires on a gap would show wrong byte values or a missing odd flag. Short preambles and a bare 0xD check that a premature delimiter match does not open a frame and produce stray bytes or an end pulse. Errors and collisions are raised both inside frames and between frames. A flag that is not gated by data-valid, or that is not cleared between frames, would turn up on a clean frame that follows.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [1:0] {
        HS_HUNT     = 2'd0,
        HS_PRE_ONE  = 2'd1,
        HS_PRE_MANY = 2'd2,
        HS_DATA     = 2'd3
    } hunt_state_t;

    typedef enum logic {
        AL_IDLE = 1'b0,
        AL_NIB  = 1'b1
    } align_state_t;

    localparam logic [3:0] PRE_NIB = 4'h5;
    localparam logic [3:0] SFD_NIB = 4'hD;

    typedef struct packed {
        logic odd;
        logic rxer;
        logic col;
        logic bad;
    } eof_flags_t;

    function automatic hunt_state_t hunt_next(input hunt_state_t cur, input logic [3:0] nib);
        hunt_state_t nxt;
        nxt = HS_HUNT;
        case (cur)
            HS_HUNT:     nxt = (nib == PRE_NIB) ? HS_PRE_ONE : HS_HUNT;
            HS_PRE_ONE:  nxt = (nib == PRE_NIB) ? HS_PRE_MANY : HS_HUNT;
            HS_PRE_MANY: nxt = (nib == PRE_NIB) ? HS_PRE_MANY :
                               (nib == SFD_NIB) ? HS_DATA : HS_HUNT;
            HS_DATA:     nxt = HS_DATA;
            default:     nxt = HS_HUNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/mii_rx_sfd_hunt.sv
module mii_rx_sfd_hunt
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dv_i,
    input  logic       nib_vld_i,
    input  logic [3:0] nib_i,
    output logic       start_o,
    output logic       data_acc_o,
    output logic       frame_end_o
);

    hunt_state_t st;
    logic        acc;

    assign acc         = dv_i && nib_vld_i;
    assign start_o     = acc && (st == HS_PRE_MANY) && (nib_i == SFD_NIB);
    assign data_acc_o  = acc && (st == HS_DATA);
    assign frame_end_o = !dv_i && (st == HS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= HS_HUNT;
        end else if (!dv_i) begin
            st <= HS_HUNT;
        end else if (acc) begin
            st <= hunt_next(st, nib_i);
        end
    end

    // Entering the data state needs a delimiter taken after two or more preamble nibbles
    assert_data_needs_sfd_R2: assert property (@(posedge clk) disable iff (rst)
        (st == HS_DATA) && ($past(st) != HS_DATA) |->
            ($past(st) == HS_PRE_MANY) && ($past(nib_i) == SFD_NIB) && $past(nib_vld_i));

endmodule

// File: rtl/mii_rx_pairer.sv
module mii_rx_pairer
    import mii_rx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         data_acc_i,
    input  logic [3:0]   nib_i,
    output logic [7:0]   byte_o,
    output logic         byte_vld_o,
    output align_state_t align_o
);

    logic [3:0] lo_nib;

    always_ff @(posedge clk) begin
        if (rst) begin
            align_o    <= AL_IDLE;
            lo_nib     <= '0;
            byte_o     <= '0;
            byte_vld_o <= 1'b0;
        end else if (start_i) begin
            align_o    <= AL_IDLE;
            byte_vld_o <= 1'b0;
        end else if (data_acc_i) begin
            if (align_o == AL_IDLE) begin
                lo_nib     <= nib_i;
                align_o    <= AL_NIB;
                byte_vld_o <= 1'b0;
            end else begin
                byte_o     <= {nib_i, lo_nib};
                align_o    <= AL_IDLE;
                byte_vld_o <= 1'b1;
            end
        end else begin
            byte_vld_o <= 1'b0;
        end
    end

    assert_strobe_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o);

    assert_strobe_needs_nibble_R5: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(data_acc_i));

endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status
    import mii_rx_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dv_i,
    input  logic             er_i,
    input  logic             col_i,
    input  logic             start_i,
    input  logic             data_acc_i,
    input  logic             frame_end_i,
    input  align_state_t     align_i,
    output logic             cnt_lsb_o,
    output logic             eof_o,
    output logic [LEN_W-1:0] eof_len_o,
    output eof_flags_t       eof_flags_o
);

    localparam int CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] nib_cnt;
    logic             seen_er;
    logic             seen_col;
    logic             odd_now;

    assign cnt_lsb_o = nib_cnt[0];
    assign odd_now   = (align_i == AL_NIB);

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_cnt <= '0;
        end else if (start_i) begin
            nib_cnt <= '0;
        end else if (data_acc_i) begin
            nib_cnt <= nib_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !dv_i) begin
            seen_er  <= 1'b0;
            seen_col <= 1'b0;
        end else begin
            seen_er  <= seen_er  | er_i;
            seen_col <= seen_col | col_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eof_o       <= 1'b0;
            eof_len_o   <= '0;
            eof_flags_o <= '0;
        end else begin
            eof_o <= frame_end_i;
            if (frame_end_i) begin
                eof_len_o        <= nib_cnt[CNT_W-1:1];
                eof_flags_o.odd  <= odd_now;
                eof_flags_o.rxer <= seen_er;
                eof_flags_o.col  <= seen_col;
                eof_flags_o.bad  <= odd_now | seen_er | seen_col;
            end else begin
                eof_len_o   <= '0;
                eof_flags_o <= '0;
            end
        end
    end

    assert_eof_single_R7: assert property (@(posedge clk) disable iff (rst)
        eof_o |=> !eof_o);

    assert_eof_after_dv_low_R7: assert property (@(posedge clk) disable iff (rst)
        eof_o |-> !$past(dv_i));

endmodule

// File: rtl/mii_rx_aligner.sv
module mii_rx_aligner
    import mii_rx_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       rx_nib_i,
    input  logic             rx_nib_vld_i,
    input  logic             rx_dv_i,
    input  logic             rx_er_i,
    input  logic             rx_col_i,
    output logic [7:0]       byte_o,
    output logic             byte_vld_o,
    output logic             eof_o,
    output logic [LEN_W-1:0] eof_len_o,
    output logic             eof_odd_o,
    output logic             eof_rxer_o,
    output logic             eof_col_o,
    output logic             eof_bad_o
);

    logic         start;
    logic         data_acc;
    logic         frame_end;
    align_state_t align;
    logic         cnt_lsb;
    eof_flags_t   flags;

    mii_rx_sfd_hunt u_hunt (
        .clk         (clk),
        .rst         (rst),
        .dv_i        (rx_dv_i),
        .nib_vld_i   (rx_nib_vld_i),
        .nib_i       (rx_nib_i),
        .start_o     (start),
        .data_acc_o  (data_acc),
        .frame_end_o (frame_end)
    );

    mii_rx_pairer u_pair (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .data_acc_i (data_acc),
        .nib_i      (rx_nib_i),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o),
        .align_o    (align)
    );

    mii_rx_status #(.LEN_W(LEN_W)) u_stat (
        .clk         (clk),
        .rst         (rst),
        .dv_i        (rx_dv_i),
        .er_i        (rx_er_i),
        .col_i       (rx_col_i),
        .start_i     (start),
        .data_acc_i  (data_acc),
        .frame_end_i (frame_end),
        .align_i     (align),
        .cnt_lsb_o   (cnt_lsb),
        .eof_o       (eof_o),
        .eof_len_o   (eof_len_o),
        .eof_flags_o (flags)
    );

    assign eof_odd_o  = flags.odd;
    assign eof_rxer_o = flags.rxer;
    assign eof_col_o  = flags.col;
    assign eof_bad_o  = flags.bad;

    // The toggle in the pairer and the counter LSB in the status block must agree
    assert_align_matches_count_R9: assert property (@(posedge clk) disable iff (rst)
        (align == AL_NIB) == cnt_lsb);

    assert_odd_frame_bad_R9: assert property (@(posedge clk) disable iff (rst)
        eof_o && eof_odd_o |-> eof_bad_o);

endmodule

// File: tb/mii_rx_aligner_test.sv
module mii_rx_aligner_test;

    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       rx_nib_i = '0;
    logic             rx_nib_vld_i = 1'b0;
    logic             rx_dv_i = 1'b0;
    logic             rx_er_i = 1'b0;
    logic             rx_col_i = 1'b0;
    logic [7:0]       byte_o;
    logic             byte_vld_o;
    logic             eof_o;
    logic [LEN_W-1:0] eof_len_o;
    logic             eof_odd_o, eof_rxer_o, eof_col_o, eof_bad_o;

    always #2 clk = ~clk;

    mii_rx_aligner #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst),
        .rx_nib_i(rx_nib_i), .rx_nib_vld_i(rx_nib_vld_i), .rx_dv_i(rx_dv_i),
        .rx_er_i(rx_er_i), .rx_col_i(rx_col_i),
        .byte_o(byte_o), .byte_vld_o(byte_vld_o),
        .eof_o(eof_o), .eof_len_o(eof_len_o), .eof_odd_o(eof_odd_o),
        .eof_rxer_o(eof_rxer_o), .eof_col_o(eof_col_o), .eof_bad_o(eof_bad_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q [0:511];
    int wr = 0, rd = 0;
    int eof_seen = 0;
    int e_len = 0;
    bit e_odd, e_rxer, e_col, e_bad;
    bit prev_vld = 0;
    bit run_mon = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pay(input int seed, input int k, input bit flat);
        if (flat) return 4'hA;
        return 4'((seed * 7 + k * 5 + 3) & 15);
    endfunction

    always @(negedge clk) begin
        if (run_mon) begin
            if (byte_vld_o) begin
                chk(!prev_vld, "R6 strobe on consecutive cycles", 1, 0);
                if (rd < wr) chk(byte_o == exp_q[rd], "R4 byte value", int'(byte_o), int'(exp_q[rd]));
                else         chk(1'b0, "R3 unexpected byte", int'(byte_o), -1);
                rd++;
            end
            prev_vld = byte_vld_o;
            if (eof_o) begin
                eof_seen++;
                chk(int'(eof_len_o) == e_len, "R8 length", int'(eof_len_o), e_len);
                chk(eof_odd_o == e_odd, "R9 odd flag", int'(eof_odd_o), int'(e_odd));
                chk(eof_rxer_o == e_rxer, "R10 rxer flag", int'(eof_rxer_o), int'(e_rxer));
                chk(eof_col_o == e_col, "R11 col flag", int'(eof_col_o), int'(e_col));
                chk(eof_bad_o == e_bad, "R12 bad flag", int'(eof_bad_o), int'(e_bad));
            end
        end
    end

    task automatic drive(input bit dv, input bit vld, input logic [3:0] n, input bit er, input bit col);
        @(negedge clk);
        rx_dv_i = dv; rx_nib_vld_i = vld; rx_nib_i = n; rx_er_i = er; rx_col_i = col;
    endtask

    task automatic frame(input int pre5, input bit sfd, input int nn, input int seed,
                         input bit gaps, input int er_at, input int col_at, input bit expect_eof);
        int eof_before;
        eof_before = eof_seen;
        if (expect_eof) begin
            for (int b = 0; b < nn / 2; b++)
                exp_q[wr + b] = {pay(seed, 2*b+1, 0), pay(seed, 2*b, 0)};
            wr = wr + nn / 2;
            e_len  = nn / 2;
            e_odd  = (nn % 2) == 1;
            e_rxer = er_at >= 0;
            e_col  = col_at >= 0;
            e_bad  = e_odd || e_rxer || e_col;
        end
        for (int i = 0; i < pre5; i++) drive(1, 1, 4'h5, 0, 0);
        if (sfd) drive(1, 1, 4'hD, 0, 0);
        for (int k = 0; k < nn; k++) begin
            if (gaps && (k % 2 == 1)) drive(1, 0, 4'h5, 0, 0);   // R5 junk on idle strobe
            drive(1, 1, pay(seed, k, !expect_eof), k == er_at, k == col_at);
        end
        for (int i = 0; i < 6; i++) drive(0, 0, 4'h0, 0, 0);
        chk(eof_seen == eof_before + (expect_eof ? 1 : 0), "R7 end pulse count",
            eof_seen - eof_before, expect_eof ? 1 : 0);
        chk(rd == wr, "R3 bytes drained", rd, wr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R7 watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!byte_vld_o && !eof_o && !eof_bad_o && !eof_odd_o, "R1 outputs in reset", 1, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!byte_vld_o && !eof_o && eof_len_o == 0 && !eof_rxer_o && !eof_col_o,
            "R1 outputs after reset", 1, 0);
        run_mon = 1;

        // R4 R8 R9 sweep of nibble counts, with and without gaps
        for (int g = 0; g < 2; g++)
            for (int nn = 0; nn < 10; nn++)
                frame(2 + nn % 6, 1, nn, nn + 3 * g, g[0], -1, -1, 1);
        frame(15, 1, 64, 9, 0, -1, -1, 1);

        // R2 delimiter after a single preamble nibble, and a bare delimiter
        frame(1, 1, 8, 0, 0, -1, -1, 0);
        frame(0, 1, 6, 0, 0, -1, -1, 0);
        frame(3, 0, 6, 0, 0, -1, -1, 0);

        // R10 R11 errors and collisions inside frames
        frame(7, 1, 8, 4, 0, 2, -1, 1);
        frame(7, 1, 8, 5, 1, -1, 5, 1);
        frame(4, 1, 7, 6, 0, 0, 6, 1);
        // R12 clean frame right after a bad one
        frame(4, 1, 6, 7, 0, -1, -1, 1);

        // R10 R11 errors and collisions while dv is low are ignored
        for (int i = 0; i < 3; i++) drive(0, 1, 4'h5, 1, 1);
        frame(5, 1, 10, 8, 1, -1, -1, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule